// File: doc/BRIEF.md
# Multi-Radix Trivium Keystream Generator

This block is a synchronous Trivium stream-cipher core. Its 288-bit state is held as three shift registers arranged in a ring, each register feeding the next. A load strobe seeds the state from an 80-bit key and an 80-bit initial value. While the run enable is high, the state advances. The first 1152 single-bit steps after a load form a warm-up and produce no output. After the warm-up, every run clock delivers a word of keystream bits together with a valid flag.

A compile-time radix chooses how many steps are taken per clock. The feedback is unrolled so that RADIX successive steps are computed in one cycle, and RADIX keystream bits leave per clock. The keystream is identical for every radix, and only its packing into words differs. The intended radices are 1, 2, 8 and 16. Any radix up to 64 that divides 1152 is accepted, so the warm-up always lasts exactly 1152/RADIX clocks.

Top module: `trv_keystream`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ks_valid_o` is 0 and `ks_o` is all zeros.
- R2: A clock with `load_i` high seeds the state: `key_i[i]` goes to state position i, and `iv_i[i]` goes to position 93+i (i = 0..79). Positions 285, 286 and 287 are set to 1 and all other positions are 0. `load_i` takes priority over `run_i`.
- R3: One step computes, with 0-based positions, ta = s65^s92^(s90&s91)^s170, tb = s161^s176^(s174&s175)^s263, tc = s242^s287^(s285&s286)^s68, and the output bit z = s65^s92^s161^s176^s242^s287. The step then shifts positions 0..92, 93..176 and 177..287 each up by one, entering tc at 0, ta at 93 and tb at 177.
- R4: After a load, `ks_valid_o` stays 0 during the first 1152/RADIX clocks with `run_i` high. It is 1 after the next such clock.
- R5: Within a valid word, bit j is the keystream bit of the j-th step taken in that clock. Bit 0 is the earliest, so the concatenated words equal the serial keystream, starting with the bit produced by step 1153.
- R6: A clock with `run_i` and `load_i` both low leaves the state and the warm-up progress unchanged and gives `ks_valid_o` = 0. The stream resumes without a gap on the next run clock.
- R7: A load issued while the keystream is flowing drops `ks_valid_o` on the next cycle and restarts the full warm-up.
- R8: The radices 1, 2, 8 and 16 all produce the same bit sequence for the same key and IV.
- R9: Whenever `ks_valid_o` is 0, `ks_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_i | input | 80 | Secret key, sampled on a load clock |
| iv_i | input | 80 | Initial value, sampled on a load clock |
| load_i | input | 1 | Seed the state and restart the warm-up |
| run_i | input | 1 | Advance RADIX steps this clock |
| ks_o | output | RADIX | Keystream word, bit 0 earliest |
| ks_valid_o | output | 1 | Keystream word is valid |

## Verification
The assertions assume that `load_i` and `run_i` are synchronous to `clk`. They also assume that reset is applied before the first load, so the counter and the state start from known values. The key and IV matter only on a load clock. The bench changes every input at the falling edge, holds reset for several cycles before the first load, and issues a load together with run as well as loads in the middle of a stream. This exercises the load-over-run priority without driving any input near the active edge.

// File: rtl/trv_pkg.sv
`timescale 1ns/1ps
package trv_pkg;
    localparam int unsigned KEY_W      = 80;
    localparam int unsigned IV_W       = 80;
    localparam int unsigned LEN_A      = 93;
    localparam int unsigned LEN_B      = 84;
    localparam int unsigned LEN_C      = 111;
    localparam int unsigned STATE_W    = LEN_A + LEN_B + LEN_C;
    localparam int unsigned HEAD_B     = LEN_A;
    localparam int unsigned HEAD_C     = LEN_A + LEN_B;
    localparam int unsigned WARM_STEPS = 1152;

    typedef logic [STATE_W-1:0] trv_state_t;

    // Seed layout: key at the head of ring A, IV at the head of ring B,
    // top three positions of ring C set.
    function automatic trv_state_t trv_seed(input logic [KEY_W-1:0] key,
                                            input logic [IV_W-1:0]  iv);
        trv_state_t s;
        s = '0;
        s[KEY_W-1:0]             = key;
        s[HEAD_B +: IV_W]        = iv;
        s[STATE_W-1:STATE_W-3]   = 3'b111;
        return s;
    endfunction
endpackage

// File: rtl/trv_step.sv
`timescale 1ns/1ps
module trv_step
    import trv_pkg::*;
(
    input  trv_state_t s_i,
    output trv_state_t s_o,
    output logic       z_o
);
    logic lin_a, lin_b, lin_c;
    logic fb_a, fb_b, fb_c;

    always_comb begin
        lin_a = s_i[65]  ^ s_i[HEAD_B-1];
        lin_b = s_i[161] ^ s_i[HEAD_C-1];
        lin_c = s_i[242] ^ s_i[STATE_W-1];
        z_o   = lin_a ^ lin_b ^ lin_c;
        fb_a  = lin_a ^ (s_i[90]  & s_i[91])  ^ s_i[170];
        fb_b  = lin_b ^ (s_i[174] & s_i[175]) ^ s_i[263];
        fb_c  = lin_c ^ (s_i[285] & s_i[286]) ^ s_i[68];
        // ring A <- fb_c, ring B <- fb_a, ring C <- fb_b
        s_o   = {s_i[STATE_W-2:HEAD_C], fb_b,
                 s_i[HEAD_C-2:HEAD_B], fb_a,
                 s_i[HEAD_B-2:0],      fb_c};
    end
endmodule

// File: rtl/trv_unroll.sv
`timescale 1ns/1ps
module trv_unroll
    import trv_pkg::*;
#(
    parameter int unsigned RADIX = 8
) (
    input  trv_state_t       s_i,
    output trv_state_t       s_o,
    output logic [RADIX-1:0] z_o
);
    trv_state_t chain [RADIX+1];

    assign chain[0] = s_i;

    for (genvar g = 0; g < RADIX; g++) begin : g_step
        trv_step u_step (
            .s_i (chain[g]),
            .s_o (chain[g+1]),
            .z_o (z_o[g])
        );
    end

    assign s_o = chain[RADIX];
endmodule

// File: rtl/trv_warmup.sv
`timescale 1ns/1ps
module trv_warmup #(
    parameter int unsigned WARM_CLKS = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic adv_i,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(WARM_CLKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == CNT_W'(WARM_CLKS));

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (adv_i && !done_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WARM_CLKS));
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> done_o);
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !adv_i) |=> $stable(cnt_q));
    p_clear_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/trv_keystream.sv
`timescale 1ns/1ps
module trv_keystream
    import trv_pkg::*;
#(
    parameter int unsigned RADIX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [79:0]      key_i,
    input  logic [79:0]      iv_i,
    input  logic             load_i,
    input  logic             run_i,
    output logic [RADIX-1:0] ks_o,
    output logic             ks_valid_o
);
    localparam int unsigned WARM_CLKS = WARM_STEPS / RADIX;

    if ((RADIX < 1) || (RADIX > 64) || ((WARM_STEPS % RADIX) != 0)) begin : g_bad_radix
        $error("trv_keystream: RADIX must divide 1152 and be at most 64");
    end

    typedef struct packed {
        trv_state_t       st;
        logic [RADIX-1:0] ks;
        logic             vld;
    } regs_t;

    regs_t            r_d, r_q;
    trv_state_t       st_adv;
    logic [RADIX-1:0] z_word;
    logic             warm_done;

    trv_unroll #(.RADIX(RADIX)) u_unroll (
        .s_i (r_q.st),
        .s_o (st_adv),
        .z_o (z_word)
    );

    trv_warmup #(.WARM_CLKS(WARM_CLKS)) u_warmup (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .adv_i   (run_i),
        .done_o  (warm_done)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        r_d.ks  = '0;
        if (load_i) begin
            r_d.st = trv_seed(key_i, iv_i);
        end else if (run_i) begin
            r_d.st  = st_adv;
            r_d.vld = warm_done;
            r_d.ks  = warm_done ? z_word : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ks_o       = r_q.ks;
    assign ks_valid_o = r_q.vld;

    p_valid_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |-> $past(run_i && !load_i));
    p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(r_q.st));
    p_valid_after_warm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |-> $past(warm_done));
    p_load_drops_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ks_valid_o);
    p_zero_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_valid_o |-> (ks_o == '0));
    p_seed_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (r_q.st[STATE_W-1:STATE_W-3] == 3'b111));
endmodule

// File: tb/trv_keystream_tb.sv
`timescale 1ns/1ps
module trv_keystream_tb;
    localparam int REFN = 96;
    localparam int WSTEPS = 1152;
    localparam int WID [4] = '{1, 2, 8, 16};

    typedef struct packed {
        logic [79:0] key;
        logic [79:0] iv;
        logic [15:0] pause_at;
        logic        with_run;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{key: 80'h0,                        iv: 80'h0,                        pause_at: 16'd0,    with_run: 1'b0},
        '{key: {80{1'b1}},                   iv: 80'h0123_4567_89AB_CDEF_0F1E, pause_at: 16'd1160, with_run: 1'b1},
        '{key: 80'h8000_0000_0000_0000_0001, iv: {80{1'b1}},                   pause_at: 16'd1200, with_run: 1'b0},
        '{key: 80'h5A5A_C3C3_1234_9876_FEDC, iv: 80'hA5A5_0000_FFFF_1357_2468, pause_at: 16'd0,    with_run: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] key = '0;
    logic [79:0] iv = '0;
    logic        load = 1'b0;
    logic        run = 1'b0;

    logic [0:0]  ks1;
    logic [1:0]  ks2;
    logic [7:0]  ks8;
    logic [15:0] ks16;
    logic [3:0]  vld;
    logic [63:0] wd [4];

    int n_chk = 0;
    int n_err = 0;
    int ptr [4];
    logic [REFN-1:0] exp_bits;

    always #10 clk = ~clk;

    trv_keystream #(.RADIX(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .key_i(key), .iv_i(iv), .load_i(load), .run_i(run),
        .ks_o(ks8), .ks_valid_o(vld[2]));
    trv_keystream #(.RADIX(1)) u_dut_r1 (
        .clk(clk), .rst_n(rst_n), .key_i(key), .iv_i(iv), .load_i(load), .run_i(run),
        .ks_o(ks1), .ks_valid_o(vld[0]));
    trv_keystream #(.RADIX(2)) u_dut_r2 (
        .clk(clk), .rst_n(rst_n), .key_i(key), .iv_i(iv), .load_i(load), .run_i(run),
        .ks_o(ks2), .ks_valid_o(vld[1]));
    trv_keystream #(.RADIX(16)) u_dut_r16 (
        .clk(clk), .rst_n(rst_n), .key_i(key), .iv_i(iv), .load_i(load), .run_i(run),
        .ks_o(ks16), .ks_valid_o(vld[3]));

    assign wd[0] = 64'(ks1);
    assign wd[1] = 64'(ks2);
    assign wd[2] = 64'(ks8);
    assign wd[3] = 64'(ks16);

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Serial model on three separate 1-based rings.
    task automatic build_ref(input logic [79:0] k, input logic [79:0] v);
        logic ra [1:93];
        logic rb [1:84];
        logic rc [1:111];
        logic t1, t2, t3;
        for (int i = 1; i <= 93; i++) ra[i] = (i <= 80) ? k[i-1] : 1'b0;
        for (int i = 1; i <= 84; i++) rb[i] = (i <= 80) ? v[i-1] : 1'b0;
        for (int i = 1; i <= 111; i++) rc[i] = (i >= 109);
        for (int n = 0; n < WSTEPS + REFN; n++) begin
            t1 = ra[66] ^ ra[93];
            t2 = rb[69] ^ rb[84];
            t3 = rc[66] ^ rc[111];
            if (n >= WSTEPS) exp_bits[n-WSTEPS] = t1 ^ t2 ^ t3;
            t1 = t1 ^ (ra[91] & ra[92]) ^ rb[78];
            t2 = t2 ^ (rb[82] & rb[83]) ^ rc[87];
            t3 = t3 ^ (rc[109] & rc[110]) ^ ra[69];
            for (int i = 93; i > 1; i--) ra[i] = ra[i-1];
            for (int i = 84; i > 1; i--) rb[i] = rb[i-1];
            for (int i = 111; i > 1; i--) rc[i] = rc[i-1];
            ra[1] = t3;
            rb[1] = t1;
            rc[1] = t2;
        end
    endtask

    task automatic check_dut(input int d, input bit ran, input int k);
        logic vexp;
        logic [63:0] e;
        vexp = ran && (k > WSTEPS / WID[d]);
        chk(vld[d] == vexp, ran ? "R4 valid timing" : "R6 valid while halted",
            64'(vld[d]), 64'(vexp));
        if (vld[d]) begin
            if (ptr[d] + WID[d] <= REFN) begin
                e = '0;
                for (int j = 0; j < WID[d]; j++) e[j] = exp_bits[ptr[d] + j];
                chk(wd[d] == e, "R3/R5/R8 keystream word", wd[d], e);
                ptr[d] += WID[d];
            end
        end else begin
            chk(wd[d] == 64'd0, "R9 word zero while invalid", wd[d], 64'd0);
        end
    endtask

    task automatic run_case(input vec_t v, input bit mid_stream);
        int k;
        int halt;
        build_ref(v.key, v.iv);
        @(negedge clk);
        key = v.key;
        iv = v.iv;
        load = 1'b1;
        run = v.with_run;
        @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            ptr[d] = 0;
            chk(vld[d] == 1'b0, v.with_run ? "R2 load beats run" :
                (mid_stream ? "R7 reload drops valid" : "R2 load clock"),
                64'(vld[d]), 64'd0);
        end
        load = 1'b0;
        run = 1'b1;
        key = ~v.key;
        iv = ~v.iv;
        k = 0;
        halt = 0;
        while (k < WSTEPS + REFN + 1) begin
            @(negedge clk);
            if (run) k++;
            for (int d = 0; d < 4; d++) check_dut(d, run, k);
            if (v.pause_at != 0 && k == int'(v.pause_at) && halt == 0) begin
                run = 1'b0;
                halt = 1;
            end else if (halt > 0 && halt < 4) begin
                halt++;
                if (halt == 4) run = 1'b1;
            end
        end
        for (int d = 0; d < 4; d++)
            chk(ptr[d] == REFN, "R8 stream length per radix", 64'(ptr[d]), 64'(REFN));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            chk(vld[d] == 1'b0, "R1 reset valid", 64'(vld[d]), 64'd0);
            chk(wd[d] == 64'd0, "R1 reset word", wd[d], 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 4; d++)
            chk(vld[d] == 1'b0, "R1 valid after reset release", 64'(vld[d]), 64'd0);
        for (int n = 0; n < 4; n++) run_case(VEC[n], n != 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule